// File: doc/BRIEF.md
# UART Idle Line Detector

This block sits beside a UART receiver and decides when the receive line has gone quiet. It runs at bit-time resolution. On each bit-time strobe it looks at the sampled line level and counts consecutive high bit times. Once the count reaches one full character time, it raises a sticky idle flag. The character time is configurable from 10 to 13 bit times. Software clears the flag by writing a 1 to its clear input.

A mode input selects when a character's high bits start to count.

- With the mode at 0, counting runs straight on from the end of the start bit. The high data bits and the stop bits of an all-ones character therefore already count toward the idle time.
- With the mode at 1, everything between the start-bit-done and stop-bits-done indications is held out of the count. Only line time after the stop bits counts.

The detector reports one idle period once. It then stays disarmed until the receiver stores a new character or a break event is flagged. Out of reset it is disarmed, so a line that has been idle since power-up never raises the flag.

Top module: `uart_idle_detect`

## Requirements
- R1: After reset `idle_flag` is 0 and the detector is disarmed.
- R2: When armed, `idle_flag` reads 1 from the first cycle after the bit tick that completes the required number of consecutive counted high bit times. After one fewer such ticks it is still 0.
- R3: A bit tick with `rx_level` low restarts the high-bit count from zero.
- R4: With `cnt_after_stop`=0, the high data bits and the high stop bit of a frame count toward the idle time. The count starts after `start_done`.
- R5: With `cnt_after_stop`=1, bit ticks that fall between a `start_done` pulse and the next `stop_done` pulse hold the count at zero. Counting starts only after `stop_done`.
- R6: The required idle length is `char_len` clamped to the range 10..13. A value below 10 acts as 10, and a value above 13 acts as 13.
- R7: A cycle with `idle_clr`=1 clears `idle_flag` on the next cycle. If the flag sets in the same cycle as a clear, the set wins.
- R8: After the flag has set, it does not set again while the detector stays disarmed, however many further high bit times follow.
- R9: A `char_stored` pulse or a `break_set` pulse rearms the detector, so a following full idle period sets the flag again.
- R10: Before the first rearm after reset, no run of high bit times sets the flag.
- R11: `rx_level` is ignored in cycles where `bit_tick` is 0. Low levels there do not restart the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| rx_level | input | 1 | Sampled receive line level, valid with `bit_tick` |
| start_done | input | 1 | Pulse: start bit of a frame has been received |
| stop_done | input | 1 | Pulse: stop bits of a frame have been received |
| char_len | input | 4 | Idle length in bit times (clamped to 10..13) |
| cnt_after_stop | input | 1 | 0: count from after start bit; 1: count from after stop bits |
| char_stored | input | 1 | Pulse: a character was written to the receive buffer (rearm) |
| break_set | input | 1 | Pulse: break flag was set (rearm) |
| idle_clr | input | 1 | Write-1-to-clear strobe for the idle flag |
| idle_flag | output | 1 | Sticky idle-line flag |

## Verification
The bench runs idle periods one tick short of the limit and exactly at it. A detector that is off by one tick would fire early or late. The same frame is sent in both counting modes. If the wrong mode were honoured, the all-ones frame would either fire right after the stop bit or need ten further ticks. The bench also leaves the line high for long stretches after a clear, without rearming and before the first rearm after reset. A design that rearmed by itself would raise the flag a second time there. A set in the same cycle as a clear, out-of-range lengths, and low levels driven without a tick are also applied. Each has its own wrong outcome: a dropped flag, no clamping, or a spurious count restart.

// File: rtl/uid_pkg.sv
package uid_pkg;
  // Saturate a requested character length into the supported window.
  function automatic int unsigned clamp_len(int unsigned req,
                                            int unsigned lo,
                                            int unsigned hi);
    if (req < lo)      return lo;
    else if (req > hi) return hi;
    else               return req;
  endfunction

  // Counter width able to hold values 0..max_val.
  function automatic int unsigned cnt_bits(int unsigned max_val);
    return $clog2(max_val + 1);
  endfunction
endpackage

// File: rtl/uid_frame_track.sv
module uid_frame_track (
  input  logic clk,
  input  logic rst_n,
  input  logic start_done,
  input  logic stop_done,
  input  logic cnt_after_stop,
  output logic in_frame,
  output logic hold_zero
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          in_frame <= 1'b0;
    else if (stop_done)  in_frame <= 1'b0;
    else if (start_done) in_frame <= 1'b1;
  end

  // In after-stop mode, bits inside a frame must not count.
  assign hold_zero = cnt_after_stop & in_frame;

  AST_STOP_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    stop_done |=> !in_frame);  // R5
endmodule

// File: rtl/uid_bit_counter.sv
module uid_bit_counter #(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned MAX_LEN = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             rx_level,
  input  logic             hold_zero,
  input  logic [CNT_W-1:0] eff_len,
  output logic [CNT_W-1:0] hi_cnt,
  output logic             full_hit
);
  logic [CNT_W-1:0] len_m1;
  logic             restart;
  logic             can_inc;

  assign len_m1   = eff_len - CNT_W'(1);
  assign restart  = ~rx_level | hold_zero;
  assign can_inc  = hi_cnt < eff_len;
  // The tick that moves the count onto the limit is the idle event.
  assign full_hit = bit_tick & ~restart & (hi_cnt == len_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt <= '0;
    end else if (bit_tick) begin
      if (restart)      hi_cnt <= '0;
      else if (can_inc) hi_cnt <= hi_cnt + CNT_W'(1);
    end
  end

  AST_LOW_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !rx_level) |=> (hi_cnt == '0));  // R3
  AST_FRAME_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && hold_zero) |=> (hi_cnt == '0));  // R5
  AST_NO_TICK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(hi_cnt));  // R11
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(hi_cnt) <= MAX_LEN));  // R6
endmodule

// File: rtl/uid_arm_ctrl.sv
module uid_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic full_hit,
  input  logic rearm,
  input  logic idle_clr,
  output logic armed,
  output logic set_ev,
  output logic idle_flag
);
  assign set_ev = full_hit & armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      idle_flag <= 1'b0;
    end else begin
      armed     <= (armed & ~set_ev) | rearm;
      idle_flag <= set_ev | (idle_flag & ~idle_clr);
    end
  end

  AST_SET_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(idle_flag) |-> $past(armed && full_hit));  // R10
  AST_CLR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_clr && !set_ev) |=> !idle_flag);  // R7
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_ev |=> idle_flag);  // R7
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    (set_ev && !rearm) |=> !armed);  // R8
endmodule

// File: rtl/uart_idle_detect.sv
module uart_idle_detect #(
  parameter int unsigned LEN_W   = 4,
  parameter int unsigned MIN_LEN = 10,
  parameter int unsigned MAX_LEN = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_tick,
  input  logic             rx_level,
  input  logic             start_done,
  input  logic             stop_done,
  input  logic [LEN_W-1:0] char_len,
  input  logic             cnt_after_stop,
  input  logic             char_stored,
  input  logic             break_set,
  input  logic             idle_clr,
  output logic             idle_flag
);
  localparam int unsigned CNT_W = uid_pkg::cnt_bits(MAX_LEN);

  logic [CNT_W-1:0] eff_len;
  logic [CNT_W-1:0] hi_cnt;
  logic             in_frame;
  logic             hold_zero;
  logic             full_hit;
  logic             rearm;
  logic             armed;
  logic             set_ev;

  assign eff_len = CNT_W'(uid_pkg::clamp_len(32'(char_len), MIN_LEN, MAX_LEN));
  assign rearm   = char_stored | break_set;

  uid_frame_track u_frame (
    .clk            (clk),
    .rst_n          (rst_n),
    .start_done     (start_done),
    .stop_done      (stop_done),
    .cnt_after_stop (cnt_after_stop),
    .in_frame       (in_frame),
    .hold_zero      (hold_zero)
  );

  uid_bit_counter #(.CNT_W(CNT_W), .MAX_LEN(MAX_LEN)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .rx_level  (rx_level),
    .hold_zero (hold_zero),
    .eff_len   (eff_len),
    .hi_cnt    (hi_cnt),
    .full_hit  (full_hit)
  );

  uid_arm_ctrl u_arm (
    .clk       (clk),
    .rst_n     (rst_n),
    .full_hit  (full_hit),
    .rearm     (rearm),
    .idle_clr  (idle_clr),
    .armed     (armed),
    .set_ev    (set_ev),
    .idle_flag (idle_flag)
  );

  AST_LEN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(eff_len) >= MIN_LEN) && (32'(eff_len) <= MAX_LEN));  // R6
  AST_REARM_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    rearm |=> armed);  // R9
  AST_FRAME_UNUSED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_frame && !cnt_after_stop) |-> !hold_zero);  // R4
endmodule

// File: tb/uart_idle_detect_tb.sv
module uart_idle_detect_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       rx_level = 1'b1;
  logic       start_done = 1'b0;
  logic       stop_done = 1'b0;
  logic [3:0] char_len = 4'd10;
  logic       cnt_after_stop = 1'b0;
  logic       char_stored = 1'b0;
  logic       break_set = 1'b0;
  logic       idle_clr = 1'b0;
  logic       idle_flag;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  uart_idle_detect u_dut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .rx_level(rx_level),
    .start_done(start_done), .stop_done(stop_done), .char_len(char_len),
    .cnt_after_stop(cnt_after_stop), .char_stored(char_stored),
    .break_set(break_set), .idle_clr(idle_clr), .idle_flag(idle_flag)
  );

  task automatic chk(string req, logic got, logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: idle_flag=%b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  // One bit time: strobe for one cycle, return at the negedge after the edge.
  task automatic tick(logic lvl);
    @(negedge clk); bit_tick = 1'b1; rx_level = lvl;
    @(negedge clk); bit_tick = 1'b0; rx_level = 1'b1;
  endtask

  task automatic highs(int n);
    for (int i = 0; i < n; i++) tick(1'b1);
  endtask

  task automatic pulse_stored();
    @(negedge clk); char_stored = 1'b1; @(negedge clk); char_stored = 1'b0;
  endtask
  task automatic pulse_break();
    @(negedge clk); break_set = 1'b1; @(negedge clk); break_set = 1'b0;
  endtask
  task automatic pulse_start();
    @(negedge clk); start_done = 1'b1; @(negedge clk); start_done = 1'b0;
  endtask
  task automatic pulse_stop();
    @(negedge clk); stop_done = 1'b1; @(negedge clk); stop_done = 1'b0;
  endtask
  task automatic clear_flag();
    @(negedge clk); idle_clr = 1'b1; @(negedge clk); idle_clr = 1'b0;
  endtask

  task automatic t_reset_and_unarmed();
    chk("R1 reset", idle_flag, 1'b0);
    tick(1'b0);
    highs(20);
    chk("R10 unarmed idle", idle_flag, 1'b0);
  endtask

  task automatic t_basic_and_once();
    char_len = 4'd10; cnt_after_stop = 1'b0;
    tick(1'b0); pulse_stored();
    highs(9);  chk("R2 one short", idle_flag, 1'b0);
    highs(1);  chk("R2 at limit", idle_flag, 1'b1);
    highs(3);  chk("R2 sticky", idle_flag, 1'b1);
    clear_flag(); chk("R7 clear", idle_flag, 1'b0);
    tick(1'b0); highs(25);
    chk("R8 no refire", idle_flag, 1'b0);
  endtask

  task automatic t_low_restart();
    tick(1'b0); pulse_stored();
    highs(9); tick(1'b0); highs(9);
    chk("R3 restart short", idle_flag, 1'b0);
    highs(1); chk("R3 full after restart", idle_flag, 1'b1);
    clear_flag();
  endtask

  task automatic send_ones_frame();
    tick(1'b0); pulse_start();
    highs(8); tick(1'b1); pulse_stop();
  endtask

  task automatic t_mode0();
    cnt_after_stop = 1'b0;
    tick(1'b0); pulse_stored();
    send_ones_frame();
    chk("R4 after frame", idle_flag, 1'b0);
    highs(1); chk("R4 frame bits counted", idle_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_mode1();
    cnt_after_stop = 1'b1;
    tick(1'b0); pulse_stored();
    send_ones_frame();
    highs(1); chk("R5 frame bits excluded", idle_flag, 1'b0);
    highs(8); chk("R5 one short", idle_flag, 1'b0);
    highs(1); chk("R5 at limit", idle_flag, 1'b1);
    clear_flag();
    cnt_after_stop = 1'b0;
  endtask

  task automatic t_len(logic [3:0] len, int eff, string req);
    char_len = len;
    tick(1'b0); pulse_stored();
    highs(eff - 1); chk(req, idle_flag, 1'b0);
    highs(1);       chk(req, idle_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_set_vs_clear();
    char_len = 4'd10;
    tick(1'b0); pulse_stored();
    highs(9);
    @(negedge clk); bit_tick = 1'b1; rx_level = 1'b1; idle_clr = 1'b1;
    @(negedge clk); bit_tick = 1'b0; idle_clr = 1'b0;
    chk("R7 set beats clear", idle_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_break_rearm();
    tick(1'b0); pulse_stored(); highs(10); clear_flag();
    tick(1'b0); tick(1'b0); pulse_break();
    highs(9);  chk("R9 break rearm short", idle_flag, 1'b0);
    highs(1);  chk("R9 break rearm", idle_flag, 1'b1);
    clear_flag();
  endtask

  task automatic t_no_tick();
    tick(1'b0); pulse_stored();
    highs(9);
    @(negedge clk); rx_level = 1'b0;
    repeat (4) @(negedge clk);
    rx_level = 1'b1;
    highs(1); chk("R11 untick low ignored", idle_flag, 1'b1);
    clear_flag();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_and_unarmed();
    t_basic_and_once();
    t_low_restart();
    t_mode0();
    t_mode1();
    t_len(4'd3,  10, "R6 low clamp");
    t_len(4'd15, 13, "R6 high clamp");
    t_len(4'd12, 12, "R6 in range");
    char_len = 4'd10;
    t_set_vs_clear();
    t_break_rearm();
    t_no_tick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, actual not done expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule